// File: doc/BRIEF.md
# Register-Mapped Eight-Pin GPIO Bank with Interrupt Detection

This block is an eight-pin general-purpose I/O bank controlled through a simple APB-style register port (select, enable phase, write strobe, 12-bit byte address, 8-bit data). Each pin can be configured as an input or an output. The pad output value and the pad output enable come straight from internal registers. Pin inputs pass through a two-flop synchronizer before anything uses them.

The data region lets software touch any subset of pins in one access, with no read-modify-write. Address bits [9:2] act as a per-pin mask, so a write changes only the selected output bits and a read returns only the selected pins. Each pin also has its own interrupt detector. It can be set to level or edge sensing, to high/rising or low/falling polarity, or to trigger on both edges. Latched edge events stay pending until software writes ones to the clear register. The enabled (masked) status bits are ORed into one interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: The direction register at offset 0x400 has bit n for pin n, where 1 makes the pin an output. `pin_oe` equals this register.
- R2: A write in the data region (address bits [11:10] = 0, bits [1:0] = 0) changes output-register bit n only when address bit n+2 is 1. `pin_out` equals the output register.
- R3: A read in the data region returns zero for every pin whose address mask bit is 0. A masked output pin returns its output-register bit, and a masked input pin returns its synchronized input.
- R4: A change on `pin_in` reaches the internal logic after two rising clock edges. A level interrupt raised by it shows on `irq` after the second edge and not after the first.
- R5: For a pin in edge mode (sense 0, both-edges 0), the polarity bit in 0x40C selects the edge: 1 for rising, 0 for falling. The detected edge sets the raw status bit (0x414), which stays set until it is cleared.
- R6: For an edge-mode pin whose bit in 0x408 is 1, both rising and falling transitions set its raw status, whatever its polarity bit.
- R7: For a pin whose bit in 0x404 is 1 (level mode), raw status is 1 exactly while the synchronized pin equals its polarity bit. Writing the clear register does not remove it while that level persists.
- R8: The masked status at 0x418 is the raw status ANDed with the enable register at 0x410. `irq` is the OR of the masked bits.
- R9: Writing 1s to offset 0x41C clears the matching latched edge bits, and bits written as 0 are left alone. Reads of 0x41C return 0.
- R10: The configuration registers at 0x404, 0x408, 0x40C and 0x410 read back what was written. Any other offset, including unaligned data addresses and offsets of 0x420 and above, reads as 0 and ignores writes.
- R11: After reset, every register is 0, `pin_out` and `pin_oe` are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access (second) phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while selected for a read |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle. A data-region write leaves the unmasked output bits untouched, and nothing but such a write moves the output register. A latched edge bit never drops without a clear. An unmapped write leaves every register as it was, and `irq` stays low while the enable register is zero. Only the bench scenarios show the rest: the edge and polarity choices, the two-cycle synchronizer latency, level status persisting through a clear, and the masked read values, because these depend on pin activity and on sequences of accesses.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned PINS   = 8;
    localparam int unsigned ADDR_W = 12;

    // Register offsets (byte addresses)
    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_POL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;

    typedef logic [PINS-1:0] pin_vec_t;

    typedef struct packed {
        pin_vec_t dout;   // output data
        pin_vec_t dir;    // 1 = output
        pin_vec_t sense;  // 1 = level, 0 = edge
        pin_vec_t both;   // 1 = both edges
        pin_vec_t pol;    // 1 = high / rising
        pin_vec_t ien;    // interrupt enable
    } gpio_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [PINS-1:0]   pwdata,
    output logic [PINS-1:0]   prdata,
    input  pin_vec_t          pin_sync,
    input  pin_vec_t          raw_stat,
    output gpio_cfg_t         cfg,
    output pin_vec_t          clr_mask
);

    localparam int unsigned MASK_LSB = 2;
    localparam int unsigned MASK_MSB = MASK_LSB + PINS - 1;

    gpio_cfg_t cfg_d, cfg_q;
    logic      wr_en, rd_en, in_data, reg_hit;
    pin_vec_t  amask, rd_val, pin_view;

    assign wr_en    = psel & penable & pwrite;
    assign rd_en    = psel & ~pwrite;
    assign in_data  = (paddr[ADDR_W-1:MASK_MSB+1] == '0) && (paddr[MASK_LSB-1:0] == '0);
    assign amask    = paddr[MASK_MSB:MASK_LSB];
    assign pin_view = (cfg_q.dir & cfg_q.dout) | (~cfg_q.dir & pin_sync);

    // Next state and write decode
    always_comb begin
        cfg_d    = cfg_q;
        clr_mask = '0;
        reg_hit  = 1'b0;
        if (!in_data) begin
            unique case (paddr)
                OFS_DIR, OFS_SENSE, OFS_BOTH, OFS_POL,
                OFS_IEN, OFS_RAW, OFS_MSK, OFS_CLR: reg_hit = 1'b1;
                default:                            reg_hit = 1'b0;
            endcase
        end
        if (wr_en) begin
            if (in_data) begin
                cfg_d.dout = (cfg_q.dout & ~amask) | (pwdata & amask);
            end else begin
                unique case (paddr)
                    OFS_DIR:   cfg_d.dir   = pwdata;
                    OFS_SENSE: cfg_d.sense = pwdata;
                    OFS_BOTH:  cfg_d.both  = pwdata;
                    OFS_POL:   cfg_d.pol   = pwdata;
                    OFS_IEN:   cfg_d.ien   = pwdata;
                    OFS_CLR:   clr_mask    = pwdata;
                    default:   ;
                endcase
            end
        end
    end

    // Read mux
    always_comb begin
        rd_val = '0;
        if (in_data) begin
            rd_val = amask & pin_view;
        end else begin
            unique case (paddr)
                OFS_DIR:   rd_val = cfg_q.dir;
                OFS_SENSE: rd_val = cfg_q.sense;
                OFS_BOTH:  rd_val = cfg_q.both;
                OFS_POL:   rd_val = cfg_q.pol;
                OFS_IEN:   rd_val = cfg_q.ien;
                OFS_RAW:   rd_val = raw_stat;
                OFS_MSK:   rd_val = raw_stat & cfg_q.ien;
                default:   rd_val = '0;
            endcase
        end
    end

    assign prdata = rd_en ? rd_val : '0;
    assign cfg    = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R2: bits outside the address mask keep their value across a data write
    a_r2_unmasked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_data) |=> (((cfg_q.dout ^ $past(cfg_q.dout)) & ~$past(amask)) == '0));

    // R2: the output register moves only on a data-region write
    a_r2_dout_only_by_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && in_data) |=> $stable(cfg_q.dout));

    // R10: a write to an unmapped offset changes no register
    a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_data && !reg_hit) |=> $stable(cfg_q));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_vec_t  pin_sync,
    input  gpio_cfg_t cfg,
    input  pin_vec_t  clr_mask,
    output pin_vec_t  raw_stat,
    output logic      irq
);

    typedef struct packed {
        pin_vec_t prev;
        pin_vec_t latch;
    } det_state_t;

    det_state_t st_d, st_q;
    pin_vec_t   rise, fall, edge_hit, level_hit;

    always_comb begin
        rise      = pin_sync & ~st_q.prev;
        fall      = ~pin_sync & st_q.prev;
        edge_hit  = ~cfg.sense & ((cfg.both & (rise | fall)) |
                                  (~cfg.both & cfg.pol & rise) |
                                  (~cfg.both & ~cfg.pol & fall));
        level_hit = cfg.sense & ~(pin_sync ^ cfg.pol);

        st_d       = st_q;
        st_d.prev  = pin_sync;
        st_d.latch = (st_q.latch & ~clr_mask) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_stat = level_hit | (~cfg.sense & st_q.latch);
    assign irq      = |(raw_stat & cfg.ien);

    // R5: a latched edge bit drops only when it was written with a 1 to the clear register
    a_r5_latch_holds_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.latch) & ~$past(clr_mask)) & ~st_q.latch) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [PINS-1:0]   pwdata,
    output logic [PINS-1:0]   prdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);

    pin_vec_t  pin_sync, raw_stat, clr_mask;
    gpio_cfg_t cfg;

    gpio_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    gpio_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pin_sync (pin_sync),
        .raw_stat (raw_stat),
        .cfg      (cfg),
        .clr_mask (clr_mask)
    );

    gpio_irq_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .cfg      (cfg),
        .clr_mask (clr_mask),
        .raw_stat (raw_stat),
        .irq      (irq)
    );

    assign pin_out = cfg.dout;
    assign pin_oe  = cfg.dir;

    // R8: with every enable bit clear the interrupt line stays low
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ien == '0) |-> !irq);

endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata, pin_out, pin_oe;
    logic [7:0]  pin_in = 8'h3C;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_bank dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h400, 8'hF0, 8'h00, 8'd1},   // R1 upper nibble outputs
        '{1'b0, 12'h400, 8'h00, 8'hF0, 8'd1},   // R1
        '{1'b1, 12'h3FC, 8'hAA, 8'h00, 8'd2},   // R2 full mask
        '{1'b0, 12'h3FC, 8'h00, 8'hAC, 8'd3},   // R3 outputs A, inputs C
        '{1'b1, 12'h040, 8'hFF, 8'h00, 8'd2},   // R2 pin 4 only
        '{1'b0, 12'h3FC, 8'h00, 8'hBC, 8'd2},   // R2
        '{1'b1, 12'h03C, 8'hFF, 8'h00, 8'd2},   // R2 pins 0..3
        '{1'b0, 12'h080, 8'h00, 8'h20, 8'd3},   // R3 pin 5 output
        '{1'b0, 12'h004, 8'h00, 8'h00, 8'd3},   // R3 pin 0 input low
        '{1'b0, 12'h010, 8'h00, 8'h04, 8'd3},   // R3 pin 2 input high
        '{1'b1, 12'h404, 8'h5A, 8'h00, 8'd10},  // R10
        '{1'b0, 12'h404, 8'h00, 8'h5A, 8'd10},
        '{1'b1, 12'h408, 8'h33, 8'h00, 8'd10},
        '{1'b0, 12'h408, 8'h00, 8'h33, 8'd10},
        '{1'b1, 12'h40C, 8'hC3, 8'h00, 8'd10},
        '{1'b0, 12'h40C, 8'h00, 8'hC3, 8'd10},
        '{1'b1, 12'h410, 8'h81, 8'h00, 8'd10},
        '{1'b0, 12'h410, 8'h00, 8'h81, 8'd10},
        '{1'b1, 12'h420, 8'hFF, 8'h00, 8'd10},  // R10 unmapped
        '{1'b0, 12'h420, 8'h00, 8'h00, 8'd10},
        '{1'b1, 12'h3FE, 8'hFF, 8'h00, 8'd10},  // R10 unaligned data write
        '{1'b0, 12'h3FC, 8'h00, 8'hBC, 8'd10},
        '{1'b0, 12'h41C, 8'h00, 8'h00, 8'd9},   // R9 clear reads zero
        '{1'b1, 12'h800, 8'hFF, 8'h00, 8'd10},
        '{1'b0, 12'h800, 8'h00, 8'h00, 8'd10},
        '{1'b0, 12'h400, 8'h00, 8'hF0, 8'd10}   // R10 dir untouched
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R11 reset state
        check("R11 pin_out", pin_out, 8'h00);
        check("R11 pin_oe", pin_oe, 8'h00);
        check("R11 irq", {7'd0, irq}, 8'h00);
        bus_read(12'h400, rd); check("R11 dir", rd, 8'h00);
        bus_read(12'h410, rd); check("R11 ien", rd, 8'h00);
        bus_read(12'h414, rd); check("R11 raw", rd, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end
        check("R1 pin_oe", pin_oe, 8'hF0);
        check("R2 pin_out", pin_out, 8'hBF);

        // Clean interrupt configuration
        bus_write(12'h400, 8'h00);
        bus_write(12'h404, 8'h00);
        bus_write(12'h408, 8'h00);
        bus_write(12'h40C, 8'h00);
        bus_write(12'h410, 8'h00);
        pin_in = 8'h00;
        settle();
        bus_write(12'h41C, 8'hFF);
        bus_read(12'h414, rd); check("R9 clear all", rd, 8'h00);

        // R5 rising edge on pin 0
        bus_write(12'h40C, 8'h01);
        bus_write(12'h410, 8'h01);
        pin_in[0] = 1'b1; settle();
        bus_read(12'h414, rd); check("R5 rising latched", rd & 8'h01, 8'h01);
        check("R8 irq on enabled", {7'd0, irq}, 8'h01);
        pin_in[0] = 1'b0; settle();
        bus_read(12'h414, rd); check("R5 held after release", rd & 8'h01, 8'h01);
        bus_write(12'h41C, 8'h01);
        bus_read(12'h414, rd); check("R9 cleared bit0", rd & 8'h01, 8'h00);
        check("R9 irq drops", {7'd0, irq}, 8'h00);

        // R5 falling edge on pin 1
        pin_in[1] = 1'b1; settle();
        bus_read(12'h414, rd); check("R5 rise ignored on falling pin", rd & 8'h02, 8'h00);
        pin_in[1] = 1'b0; settle();
        bus_read(12'h414, rd); check("R5 falling latched", rd & 8'h02, 8'h02);
        bus_read(12'h418, rd); check("R8 masked excludes disabled", rd, 8'h00);
        check("R8 irq low when masked", {7'd0, irq}, 8'h00);
        bus_write(12'h41C, 8'h01);
        bus_read(12'h414, rd); check("R9 zero bits untouched", rd & 8'h02, 8'h02);
        bus_write(12'h410, 8'h03);
        bus_read(12'h418, rd); check("R8 masked shows bit1", rd, 8'h02);
        bus_write(12'h41C, 8'h02);
        bus_write(12'h410, 8'h00);

        // R6 both edges on pin 2
        bus_write(12'h408, 8'h04);
        pin_in[2] = 1'b1; settle();
        bus_read(12'h414, rd); check("R6 rising", rd & 8'h04, 8'h04);
        bus_write(12'h41C, 8'h04);
        pin_in[2] = 1'b0; settle();
        bus_read(12'h414, rd); check("R6 falling", rd & 8'h04, 8'h04);
        bus_write(12'h41C, 8'h04);

        // R7 level mode on pin 3
        bus_write(12'h404, 8'h08);
        bus_write(12'h40C, 8'h09);
        pin_in[3] = 1'b1; settle();
        bus_read(12'h414, rd); check("R7 high level", rd & 8'h08, 8'h08);
        bus_write(12'h41C, 8'h08);
        bus_read(12'h414, rd); check("R7 clear no effect", rd & 8'h08, 8'h08);
        pin_in[3] = 1'b0; settle();
        bus_read(12'h414, rd); check("R7 level gone", rd & 8'h08, 8'h00);
        bus_write(12'h40C, 8'h01);
        bus_read(12'h414, rd); check("R7 low level", rd & 8'h08, 8'h08);

        // R4 synchronizer latency via level interrupt on pin 4
        bus_write(12'h404, 8'h18);
        bus_write(12'h40C, 8'h11);
        bus_write(12'h410, 8'h10);
        check("R4 irq idle", {7'd0, irq}, 8'h00);
        @(negedge clk); pin_in[4] = 1'b1;
        @(negedge clk); check("R4 one edge", {7'd0, irq}, 8'h00);
        @(negedge clk); check("R4 two edges", {7'd0, irq}, 8'h01);

        finish_run();
    end

endmodule